// File: doc/BRIEF.md
# SPI Master Serial-Clock and Shift Engine

This block is the master side of a serial peripheral link, running entirely on the system clock. When software pulses a start strobe, the block captures a baud value, a clock-polarity choice, a word length and a parallel transmit word. It then produces a registered serial clock whose period comes from the baud value, shifts the word out most significant bit first, and collects the same number of bits from the return line. When the last bit has been captured, a one-cycle done pulse marks the new receive word.

Only non-delayed phase timing is supported. Each data bit is driven on the edge that leaves the idle level (the active edge). The return line is captured on the edge that goes back to idle (the inactive edge). An odd divisor makes the two halves of the serial clock differ by one system clock. The half spent away from the idle level is always the shorter one. The whole transfer takes exactly word length times period system clocks. Further starts are accepted only after that.

Top module: `spi_baud_master`

## Requirements
- R1: After a synchronous active-low reset, sclk_o, mosi_o, done_o and rx_word_o are all 0, and the latched idle level is 0.
- R2: The serial clock period N, in system clocks, is baud_i+1 for baud_i of 3 or more. For baud_i of 0, 1 or 2 it is 4. So N spans 4 to 128.
- R3: Within each period, sclk_o stays away from its idle level for floor(N/2) system clocks and at its idle level for ceil(N/2) system clocks.
- R4: The idle level of sclk_o equals the cpol_i value captured at the most recent accepted start (0 before any start). The active edge leaves that level: rising for cpol 0, falling for cpol 1.
- R5: The clock edge that accepts a start is also the first active edge. mosi_o takes a new bit only on active edges, most significant bit of the word first, and holds it until the next active edge.
- R6: miso_i is sampled at each inactive edge and shifted in at the least significant end. rx_word_o then holds the received bits right-justified, with all higher bits 0.
- R7: done_o is high for exactly one cycle. It rises together with the last inactive edge, and rx_word_o updates at the same moment. A transfer of k bits occupies k*N system clocks from the accepting edge.
- R8: The word length is len_m1_i+1 bits (1 to 16). Transmit bits above that length are never sent.
- R9: While a transfer runs, start_i is ignored, and changes to baud_i, cpol_i, len_m1_i or tx_word_i do not affect it.
- R10: A start is accepted only when master_en_i is 1 and delay_phase_i is 0. Otherwise the serial clock stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en_i | input | 1 | Master operation enable |
| delay_phase_i | input | 1 | Delayed-phase request; must be 0 for a start to be taken |
| baud_i | input | 7 | Baud value; divisor is baud_i+1 with a floor of 4 |
| cpol_i | input | 1 | Clock polarity (idle level) |
| len_m1_i | input | 4 | Word length minus one |
| start_i | input | 1 | Start strobe |
| tx_word_i | input | 16 | Parallel transmit word, right-justified |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Registered serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| rx_word_o | output | 16 | Received word, right-justified |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume that miso_i is a synchronous signal, stable around the system clock edge. They also assume that configuration is only meaningful at the start edge, so that latched settings may be checked for stability throughout a transfer. The bench changes every input half a cycle away from the rising edge. It deliberately pulses start_i and changes baud, polarity, length and data in the middle of a transfer. A reference model computes the expected sclk, mosi, done and receive word each cycle. The sweep covers the collapsed divisors, odd and even divisors up to 128, both polarities, and word lengths of 1, 8 and 16.

// File: rtl/spi_baud_pkg.sv
// Package: shared sizes and the divisor rule for the SPI master engine.
// Assumes a 7-bit baud value; the divisor rule clamps small values to 4.
package spi_baud_pkg;
    localparam int BAUD_W  = 7;
    localparam int DIV_W   = BAUD_W + 1;
    localparam int MIN_DIV = 4;

    // Serial clock period in system clocks for a given baud value.
    function automatic logic [DIV_W-1:0] div_of(input logic [BAUD_W-1:0] baud);
        logic [DIV_W-1:0] n;
        n = DIV_W'(baud) + DIV_W'(1);
        if (n < DIV_W'(MIN_DIV))
            n = DIV_W'(MIN_DIV);
        return n;
    endfunction
endpackage

// File: rtl/spi_clk_div.sv
// Module: spi_clk_div
// Counts system clocks within one serial clock period. It reports the end of
// the away-from-idle half (inactive edge due) and the end of the idle half
// (period complete). The away half is floor(N/2) and the idle half ceil(N/2).
// Assumes baud_i is held stable while run_i is high.
module spi_clk_div
    import spi_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              run_i,
    input  logic [BAUD_W-1:0] baud_i,
    output logic              off_stb_o,
    output logic              end_stb_o
);
    localparam int CNT_W = DIV_W - 1;

    logic [DIV_W-1:0] div_n;
    logic [CNT_W-1:0] half_away;
    logic [CNT_W-1:0] half_idle;
    logic [CNT_W-1:0] cnt_q;
    logic             away_q;

    // Derive both half lengths from the divisor.
    always_comb begin
        div_n     = div_of(baud_i);
        half_away = CNT_W'(div_n >> 1);
        half_idle = CNT_W'(div_n - DIV_W'(half_away));
    end

    assign off_stb_o = run_i &&  away_q && (cnt_q == half_away - CNT_W'(1));
    assign end_stb_o = run_i && !away_q && (cnt_q == half_idle - CNT_W'(1));

    // Advance the in-half counter and flip the half at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            away_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= '0;
            away_q <= 1'b1;
        end else if (run_i) begin
            if (off_stb_o) begin
                cnt_q  <= '0;
                away_q <= 1'b0;
            end else if (end_stb_o) begin
                cnt_q  <= '0;
                away_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_CNT_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < (away_q ? half_away : half_idle))); // R3
    AST_AWAY_NOT_LONGER: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (half_away <= half_idle)); // R3
endmodule

// File: rtl/spi_shift_unit.sv
// Module: spi_shift_unit
// Transmit and receive shift registers. On load it aligns the word so that
// its top valid bit appears on mosi at once. Each shift presents the next bit.
// Each sample moves miso in at the low end.
// Assumes load, shift and sample are never asserted in the same cycle.
module spi_shift_unit #(
    parameter int MAXW  = 16,
    parameter int LEN_W = $clog2(MAXW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_m1_i,
    input  logic [MAXW-1:0]  tx_word_i,
    input  logic             shift_i,
    input  logic             sample_i,
    input  logic             miso_i,
    output logic             mosi_o,
    output logic [MAXW-1:0]  rx_sr_o
);
    logic [MAXW-1:0] aligned;
    logic [MAXW-1:0] tx_sr_q;
    logic            mosi_q;

    // Left-justify the transmit word according to its length.
    always_comb begin
        aligned = tx_word_i << (LEN_W'(MAXW - 1) - len_m1_i);
    end

    // Move transmit bits out, MSB first, one per active edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr_q <= '0;
            mosi_q  <= 1'b0;
        end else if (load_i) begin
            mosi_q  <= aligned[MAXW-1];
            tx_sr_q <= aligned << 1;
        end else if (shift_i) begin
            mosi_q  <= tx_sr_q[MAXW-1];
            tx_sr_q <= tx_sr_q << 1;
        end
    end

    // Collect receive bits into the low end, one per inactive edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sr_o <= '0;
        else if (load_i)
            rx_sr_o <= '0;
        else if (sample_i)
            rx_sr_o <= {rx_sr_o[MAXW-2:0], miso_i};
    end

    assign mosi_o = mosi_q;

    AST_NO_LOAD_AND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && (shift_i || sample_i))); // R9
endmodule

// File: rtl/spi_baud_master.sv
// Module: spi_baud_master (top)
// SPI master with non-delayed phase timing. A start strobe captures the
// configuration. The engine then drives a registered serial clock and shifts
// a word out while capturing one in, and pulses done at the last capture.
// Assumes miso_i is synchronous to clk.
module spi_baud_master
    import spi_baud_pkg::*;
#(
    parameter int MAXW  = 16,
    parameter int LEN_W = $clog2(MAXW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en_i,
    input  logic              delay_phase_i,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic              cpol_i,
    input  logic [LEN_W-1:0]  len_m1_i,
    input  logic              start_i,
    input  logic [MAXW-1:0]   tx_word_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic [MAXW-1:0]   rx_word_o,
    output logic              done_o
);
    logic              busy_q;
    logic [BAUD_W-1:0] baud_l;
    logic              cpol_l;
    logic [LEN_W-1:0]  bits_left_q;
    logic              sclk_q;
    logic              done_q;
    logic [MAXW-1:0]   rx_q;
    logic              accept;
    logic              last_bit;
    logic              off_stb;
    logic              end_stb;
    logic [MAXW-1:0]   rx_sr;

    assign accept   = start_i && !busy_q && master_en_i && !delay_phase_i;
    assign last_bit = (bits_left_q == '0);

    spi_clk_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .run_i     (busy_q),
        .baud_i    (baud_l),
        .off_stb_o (off_stb),
        .end_stb_o (end_stb)
    );

    spi_shift_unit #(.MAXW(MAXW), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .len_m1_i  (len_m1_i),
        .tx_word_i (tx_word_i),
        .shift_i   (end_stb && !last_bit),
        .sample_i  (off_stb),
        .miso_i    (miso_i),
        .mosi_o    (mosi_o),
        .rx_sr_o   (rx_sr)
    );

    // Transfer control: capture config, drive sclk edges, finish the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            baud_l      <= '0;
            cpol_l      <= 1'b0;
            bits_left_q <= '0;
            sclk_q      <= 1'b0;
            done_q      <= 1'b0;
            rx_q        <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q      <= 1'b1;
                baud_l      <= baud_i;
                cpol_l      <= cpol_i;
                bits_left_q <= len_m1_i;
                sclk_q      <= ~cpol_i;
            end else if (busy_q) begin
                if (off_stb) begin
                    sclk_q <= cpol_l;
                    if (last_bit) begin
                        done_q <= 1'b1;
                        rx_q   <= {rx_sr[MAXW-2:0], miso_i};
                    end
                end else if (end_stb) begin
                    if (last_bit) begin
                        busy_q <= 1'b0;
                    end else begin
                        bits_left_q <= bits_left_q - LEN_W'(1);
                        sclk_q      <= ~cpol_l;
                    end
                end
            end
        end
    end

    assign sclk_o    = sclk_q;
    assign done_o    = done_q;
    assign rx_word_o = rx_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (sclk_q == cpol_l)); // R7
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (sclk_q == cpol_l)); // R4
    AST_MOSI_ON_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_o) |-> (sclk_q != cpol_l)); // R5
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(baud_l) && $stable(cpol_l))); // R9
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !(master_en_i && !delay_phase_i)) |=> !busy_q); // R10
endmodule

// File: tb/spi_baud_master_bench.sv
module spi_baud_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en_i = 1'b0;
    logic        delay_phase_i = 1'b0;
    logic [6:0]  baud_i = '0;
    logic        cpol_i = 1'b0;
    logic [3:0]  len_m1_i = '0;
    logic        start_i = 1'b0;
    logic [15:0] tx_word_i = '0;
    logic        miso_i = 1'b0;
    logic        sclk_o, mosi_o, done_o;
    logic [15:0] rx_word_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    bit        m_busy = 0, m_sclk = 0, m_mosi = 0, m_done = 0, m_cpol = 0;
    int        m_t = 0, m_n = 4, m_h = 2, m_k = 1;
    logic [15:0] m_tx = '0, m_rx = '0, m_acc = '0;

    always #2 clk = ~clk; // 250 MHz

    spi_baud_master u_spi_baud_master (
        .clk(clk), .rst_n(rst_n), .master_en_i(master_en_i),
        .delay_phase_i(delay_phase_i), .baud_i(baud_i), .cpol_i(cpol_i),
        .len_m1_i(len_m1_i), .start_i(start_i), .tx_word_i(tx_word_i),
        .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .rx_word_o(rx_word_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Behavioural reference: period, halves and bit positions from R2..R10.
    always @(posedge clk) begin
        m_done = 0;
        if (!rst_n) begin
            m_busy = 0; m_sclk = 0; m_mosi = 0; m_cpol = 0; m_rx = '0;
        end else if (m_busy) begin
            m_t++;
            if (m_t == m_k * m_n) begin
                m_busy = 0;
            end else if (m_t % m_n == 0) begin
                m_sclk = !m_cpol;
                m_mosi = m_tx[m_k - 1 - m_t / m_n];
            end else if (m_t % m_n == m_h) begin
                m_sclk = m_cpol;
                m_acc = (m_acc << 1) | 16'(miso_i);
                if (m_t / m_n == m_k - 1) begin
                    m_done = 1;
                    m_rx = m_acc;
                end
            end
        end else if (start_i && master_en_i && !delay_phase_i) begin
            m_n = (baud_i < 3) ? 4 : int'(baud_i) + 1;
            m_h = m_n / 2;
            m_k = int'(len_m1_i) + 1;
            m_cpol = cpol_i;
            m_tx = tx_word_i;
            m_acc = '0;
            m_t = 0;
            m_busy = 1;
            m_sclk = !cpol_i;
            m_mosi = tx_word_i[m_k - 1];
        end
    end

    // Per-cycle comparison away from the active edge; miso stimulus.
    always @(negedge clk) begin
        cycles++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso_i <= lfsr[0];
        if (rst_n) begin
            check(sclk_o == m_sclk, "R2/R3/R4 sclk", sclk_o, m_sclk);
            check(mosi_o == m_mosi, "R5/R8 mosi", mosi_o, m_mosi);
            check(done_o == m_done, "R7 done", done_o, m_done);
            check(rx_word_o == m_rx, "R6 rx_word", rx_word_o, m_rx);
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic xfer(input int baud, input bit pol, input int len_m1,
                        input logic [15:0] tx, input bit disturb);
        @(negedge clk);
        baud_i = 7'(baud); cpol_i = pol; len_m1_i = 4'(len_m1); tx_word_i = tx;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        if (disturb) begin // R9: mid-transfer start and config changes
            repeat (3) @(negedge clk);
            start_i = 1; baud_i = 7'd5; cpol_i = !pol; len_m1_i = 4'd2; tx_word_i = ~tx;
            @(negedge clk);
            start_i = 0;
        end
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(sclk_o == 0 && mosi_o == 0 && done_o == 0 && rx_word_o == 0,
              "R1 reset", {sclk_o, mosi_o, done_o}, 0);
        // R10: disabled or delayed-phase starts are ignored
        start_i = 1; master_en_i = 0;
        repeat (2) @(negedge clk);
        check(sclk_o == 0, "R10 disabled", sclk_o, 0);
        master_en_i = 1; delay_phase_i = 1;
        repeat (2) @(negedge clk);
        check(sclk_o == 0, "R10 delayed phase", sclk_o, 0);
        start_i = 0; delay_phase_i = 0;
        // R2 collapsed divisors, R3 odd/even splits, R4 polarity, R8 lengths
        for (int b = 0; b < 6; b++) xfer(b, b[0], 7, 16'hA5C3, 0);
        xfer(6, 1, 15, 16'h8001, 0);
        xfer(7, 0, 0, 16'h0001, 0);
        xfer(10, 1, 0, 16'hFFFE, 0);
        xfer(126, 0, 3, 16'h000B, 0);
        xfer(127, 1, 2, 16'h0005, 0);
        xfer(4, 0, 15, 16'h1234, 1);
        xfer(9, 1, 11, 16'hFABC, 1);
        xfer(2, 1, 15, 16'hFFFF, 0);
        xfer(0, 0, 15, 16'h0000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule